// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-side controller of a small serial EEPROM. It watches a clock line and a data line that are already synchronised to the system clock, and it drives one output: an enable for the open-drain pull-down on the data line. START and STOP are found from data-line edges while the bus clock is high. Bytes are shifted in and out most significant bit first. The engine answers each accepted byte on the ninth bus clock, checks the device-select word, and keeps the word address pointer. It supports single-byte writes, page writes, reads from the current address, reads from a chosen address, and sequential reads.

Accepted write bytes go to a page buffer. A STOP commits the buffer into the internal byte array over a fixed number of system clocks. While that commit runs the engine is deaf: it ignores every START and acknowledges nothing. A host can therefore poll with device words until one is acknowledged. The density parameter (1, 2, 4, 8 or 16 kbit) sets the address width and the page size (8 bytes up to 2 kbit, 16 bytes above). It also sets how many of the three select bits are matched against the strap pins and how many serve as upper address bits.

State machine: `ST_IDLE` waits for START. `ST_DEV` shifts the device word and goes to `ST_DEV_ACK` on a match, or back to `ST_IDLE` on a mismatch. `ST_DEV_ACK` leads to `ST_RDATA` for a read or to `ST_WADDR` for a write. `ST_WADDR` is followed by `ST_WADDR_ACK` and then `ST_WDATA`. `ST_WDATA` alternates with `ST_WDATA_ACK`. `ST_RDATA` moves to `ST_RACK`, the host's answer slot. From `ST_RACK` the engine returns to `ST_RDATA` when the host acknowledges, and goes to `ST_HOLD` when it does not. Three events override the normal flow. A START sends any state to `ST_DEV`. A STOP sends any state to `ST_IDLE`. A running commit holds the engine in `ST_IDLE`.

Top module: `eep_serial_slave`

## Requirements
- R1: A falling data edge while the bus clock is high is a START. Outside a commit, a START abandons the current sequence, including a partly shifted byte, and restarts device-word decoding. Bytes not yet committed are then dropped and the pointer is left unchanged. A rising data edge while the clock is high is a STOP and returns the engine to idle.
- R2: A device word whose four upper bits are not 1010 gets no acknowledge. The engine then ignores the bus until the next START, and nothing is written.
- R3: Device-word bits 3..1 are compared with strap pins 2..0. For 1 and 2 kbit, all three bits are compared. For 4 kbit, bit 1 is address bit 8 and the other two are compared. For 8 kbit, bits 2..1 are address bits 9..8 and only bit 3 is compared. For 16 kbit, bits 3..1 are address bits 10..8 and nothing is compared. A mismatch gets no acknowledge. Device-word bit 0 set to 1 means read, and 0 means write.
- R4: Each accepted device, address or data byte is acknowledged by asserting the pull-down for the whole high phase of the ninth bus clock. Out of reset the pull-down is off.
- R5: A STOP after at least one data byte writes the buffered bytes into the array. The written data become readable once the commit ends.
- R6: During a page write the address advances only in its low page-offset bits and wraps within the page. A later byte sent to a slot that was already filled overwrites the earlier one.
- R7: A read that has no address phase starts at the pointer, which holds the last accessed address plus one.
- R8: A write sequence that carries only a word address, followed by a repeated START and a read device word, reads from that address.
- R9: While the host acknowledges, reads continue across page boundaries. After the last byte of the array the address wraps to 0.
- R10: If the host does not acknowledge a read byte, the engine releases the line and stays silent on further clocks until START or STOP. The pointer does not advance further.
- R11: While a commit runs, no START is honoured and no device word is acknowledged. The first poll right after a write STOP gets no acknowledge, and a later poll does.
- R12: Read bits are presented most significant bit first. The pull-down changes only while the bus clock is low. The line is released during the host's answer slot.
- R13: A STOP after only a word address starts no commit, so the very next device word is acknowledged. The pointer holds that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock, synchronised |
| sda_i | input | 1 | Bus data line level, synchronised |
| sel_pins_i | input | 3 | Hard-wired device-select straps |
| sda_pull_o | output | 1 | Drives the data line low when 1 |

## Verification
Two events can fall in the same system-clock cycle: the START of a host's poll and a commit that is still running. The bench provokes this by sending a device word straight after each write STOP. It expects the pull-down to stay off for that whole poll, and it expects no state to have been disturbed. Later polls must be acknowledged, and the data read back must match a behavioural byte-array model in the bench. A companion case aborts a half-shifted data byte with a START, and the bench then confirms that the next poll gets an immediate acknowledge, meaning nothing was committed.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_HOLD
    } eep_state_e;

    function automatic int addr_bits(input int kbit);
        return 7 + $clog2(kbit);
    endfunction

    function automatic int page_bytes(input int kbit);
        return (kbit <= 2) ? 8 : 16;
    endfunction

endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/eep_page_store.sv
module eep_page_store #(
    parameter int ADDR_W       = 8,
    parameter int PAGE_BYTES   = 8,
    parameter int WRITE_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              discard,
    input  logic              commit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    logic [7:0]       mem_q  [DEPTH];
    logic [7:0]       slot_q [PAGE_BYTES];
    logic             vld_q  [PAGE_BYTES];
    logic [PG_W-1:0]  page_q;
    logic [CNT_W-1:0] tmr_q;
    logic             busy_q;
    logic             done;
    logic             wr_ok;
    logic             any_vld;

    assign done  = busy_q && (tmr_q == '0);
    assign wr_ok = wr_en && !busy_q;

    always_comb begin
        any_vld = 1'b0;
        for (int i = 0; i < PAGE_BYTES; i++) any_vld = any_vld | vld_q[i];
    end

    // one buffer slot per page offset
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
                vld_q[g]  <= 1'b0;
            end else if (done || discard) begin
                vld_q[g]  <= 1'b0;
            end else if (wr_ok && wr_addr[OFF_W-1:0] == OFF_W'(g)) begin
                slot_q[g] <= wr_data;
                vld_q[g]  <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            tmr_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            if (wr_ok) page_q <= wr_addr[ADDR_W-1:OFF_W];
            if (!busy_q && commit && any_vld) begin
                busy_q <= 1'b1;
                tmr_q  <= CNT_W'(WRITE_CYCLES - 1);
            end else if (busy_q) begin
                if (tmr_q == '0) busy_q <= 1'b0;
                else             tmr_q  <= tmr_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (done) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (vld_q[i]) mem_q[{page_q, OFF_W'(i)}] <= slot_q[i];
        end
    end

    assign rd_data = mem_q[rd_addr];
    assign busy    = busy_q;

    // R5
    commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy_q);

    // R6
    page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && any_vld) |-> (wr_addr[ADDR_W-1:OFF_W] == page_q));

endmodule

// File: rtl/eep_proto_fsm.sv
module eep_proto_fsm
    import eep_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              busy,
    input  logic [2:0]        sel_pins,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              discard,
    output logic              commit,
    output logic              sda_pull
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PB    = (ADDR_W > 8) ? ADDR_W - 8 : 0;

    eep_state_e        st_q, st_d;
    logic [3:0]        cnt_q;
    logic [7:0]        shreg_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [2:0]        pg_q;
    logic              rw_q;
    logic              pull_q;
    logic              wrote_q;
    logic              hack_q;
    logic              byte_done;
    logic              sel_ok;
    logic              dev_ok;

    assign byte_done = scl_fall && (cnt_q == 4'd8);

    always_comb begin
        sel_ok = 1'b1;
        for (int i = 0; i < 3; i++)
            if (i >= PB && shreg_q[i+1] != sel_pins[i]) sel_ok = 1'b0;
    end
    assign dev_ok = (shreg_q[7:4] == 4'b1010) && sel_ok;

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (busy)           st_d = ST_IDLE;
        else if (start_det) st_d = ST_DEV;
        else if (stop_det)  st_d = ST_IDLE;
        else begin
            unique case (st_q)
                ST_IDLE:      st_d = ST_IDLE;
                ST_DEV:       if (byte_done) st_d = dev_ok ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall)  st_d = rw_q ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_done) st_d = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall)  st_d = ST_WDATA;
                ST_WDATA:     if (byte_done) st_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  st_d = ST_WDATA;
                ST_RDATA:     if (byte_done) st_d = ST_RACK;
                ST_RACK:      if (scl_fall)  st_d = hack_q ? ST_RDATA : ST_HOLD;
                ST_HOLD:      st_d = ST_HOLD;
                default:      st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath and output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            ptr_q   <= '0;
            pg_q    <= '0;
            rw_q    <= 1'b0;
            pull_q  <= 1'b0;
            wrote_q <= 1'b0;
            hack_q  <= 1'b0;
        end else if (busy) begin
            cnt_q   <= '0;
            pull_q  <= 1'b0;
            wrote_q <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt_q   <= '0;
            pull_q  <= 1'b0;
            wrote_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg_q <= {shreg_q[6:0], sda_i};
                        cnt_q   <= cnt_q + 4'd1;
                    end
                    if (byte_done) begin
                        cnt_q <= '0;
                        if (st_q == ST_DEV) begin
                            if (dev_ok) begin
                                pull_q <= 1'b1;
                                rw_q   <= shreg_q[0];
                                pg_q   <= shreg_q[3:1];
                            end
                        end else if (st_q == ST_WADDR) begin
                            pull_q <= 1'b1;
                            ptr_q  <= ADDR_W'({pg_q, shreg_q});
                        end else begin
                            pull_q  <= 1'b1;
                            wrote_q <= 1'b1;
                            ptr_q   <= {ptr_q[ADDR_W-1:OFF_W], ptr_q[OFF_W-1:0] + OFF_W'(1)};
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        cnt_q <= '0;
                        if (rw_q) begin
                            shreg_q <= rd_data;
                            pull_q  <= ~rd_data[7];
                            ptr_q   <= ptr_q + 1'b1;
                        end else begin
                            pull_q <= 1'b0;
                        end
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) pull_q <= 1'b0;
                end
                ST_RDATA: begin
                    if (scl_rise) cnt_q <= cnt_q + 4'd1;
                    if (scl_fall) begin
                        if (cnt_q == 4'd8) begin
                            pull_q <= 1'b0;
                            cnt_q  <= '0;
                        end else begin
                            shreg_q <= {shreg_q[6:0], 1'b0};
                            pull_q  <= ~shreg_q[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) hack_q <= ~sda_i;
                    if (scl_fall) begin
                        if (hack_q) begin
                            shreg_q <= rd_data;
                            pull_q  <= ~rd_data[7];
                            ptr_q   <= ptr_q + 1'b1;
                        end else begin
                            pull_q <= 1'b0;
                        end
                    end
                end
                default: pull_q <= 1'b0;
            endcase
        end
    end

    assign rd_addr  = ptr_q;
    assign wr_en    = (st_q == ST_WDATA) && byte_done && !busy;
    assign wr_addr  = ptr_q;
    assign wr_data  = shreg_q;
    assign discard  = start_det && !busy;
    assign commit   = stop_det && wrote_q && !busy;
    assign sda_pull = pull_q;

    // R1
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !busy) |=> (st_q == ST_DEV));

    // R11
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pull_q);

    // R12
    pull_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pull_q) |-> !scl_i);

endmodule

// File: rtl/eep_serial_slave.sv
module eep_serial_slave #(
    parameter int DENSITY_KBIT = 2,
    parameter int WRITE_CYCLES = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] sel_pins_i,
    output logic       sda_pull_o
);
    localparam int ADDR_W     = eep_pkg::addr_bits(DENSITY_KBIT);
    localparam int PAGE_BYTES = eep_pkg::page_bytes(DENSITY_KBIT);

    logic              scl_rise, scl_fall, start_det, stop_det;
    logic              busy, wr_en, discard, commit;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0]        rd_data, wr_data;

    eep_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eep_proto_fsm #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .busy      (busy),
        .sel_pins  (sel_pins_i),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .discard   (discard),
        .commit    (commit),
        .sda_pull  (sda_pull_o)
    );

    eep_page_store #(
        .ADDR_W       (ADDR_W),
        .PAGE_BYTES   (PAGE_BYTES),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .discard (discard),
        .commit  (commit),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .busy    (busy)
    );

endmodule

// File: tb/tb_eep_serial_slave.sv
module tb_eep_serial_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       msda = 1'b1;
    logic [2:0] pins = 3'b101;
    logic       pull;
    wire        line = msda & ~pull;

    always #10 clk = ~clk;

    eep_serial_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (line),
        .sel_pins_i (pins),
        .sda_pull_o (pull)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    logic  chk_en = 1'b0;
    logic  exp_pull = 1'b0;
    string req = "R4";
    bit    finished = 0;
    logic [7:0] mem_m [256];
    int    ptr_m = 0;

    localparam logic [7:0] DW = 8'hAA;
    localparam logic [7:0] DR = 8'hAB;

    // per-clock comparison of the pull-down against the model's expectation
    always @(negedge clk) begin
        if (chk_en) begin
            n_chk++;
            if (pull !== exp_pull) begin
                n_fail++;
                $display("FAIL %s: sda_pull=%0b expected %0b at %0t", req, pull, exp_pull, $time);
            end
        end
    end

    task automatic check(input string r, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic clk_n(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic bit_cycle(input logic b, input logic ep, input bit chk, output logic seen);
        msda = b;
        clk_n(2);
        scl = 1'b1;
        clk_n(1);
        chk_en = chk;
        exp_pull = ep;
        seen = pull;
        clk_n(2);
        chk_en = 1'b0;
        scl = 1'b0;
        clk_n(2);
    endtask

    task automatic start_c();
        msda = 1'b1; clk_n(2);
        scl = 1'b1;  clk_n(3);
        msda = 1'b0; clk_n(3);
        scl = 1'b0;  clk_n(2);
    endtask

    task automatic stop_c();
        msda = 1'b0; clk_n(2);
        scl = 1'b1;  clk_n(3);
        msda = 1'b1; clk_n(3);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic exp_ack, input bit chk, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(d[i], 1'b0, chk, s);
        bit_cycle(1'b1, exp_ack, chk, s);
        acked = s;
    endtask

    task automatic recv_byte(input logic [7:0] e, input bit hack, output logic [7:0] got);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, ~e[i], 1, s);
            got[i] = ~s;
        end
        bit_cycle(~hack, 1'b0, 1, s);
    endtask

    task automatic poll(output int tries);
        logic a;
        tries = 0;
        do begin
            start_c();
            send_byte(DW, 1'b0, 0, a);
            tries++;
            stop_c();
        end while (!a && tries < 60);
        check("R11 poll bound", int'(a), 1);
    endtask

    task automatic write_seq(input int addr, input logic [7:0] d[$]);
        logic a;
        int   t;
        int   p;
        start_c();
        send_byte(DW, 1'b1, 1, a);
        send_byte(8'(addr), 1'b1, 1, a);
        p = addr;
        foreach (d[i]) begin
            send_byte(d[i], 1'b1, 1, a);
            mem_m[p] = d[i];
            p = (p & ~7) | ((p + 1) & 7);
        end
        ptr_m = p;
        stop_c();
        poll(t);
        if (d.size() == 0) check("R13 no commit", t, 1);
        else               check("R11 first poll unanswered", int'(t > 1), 1);
    endtask

    task automatic read_seq(input int addr, input int n);
        logic       a;
        logic [7:0] g;
        if (addr >= 0) begin
            start_c();
            send_byte(DW, 1'b1, 1, a);
            send_byte(8'(addr), 1'b1, 1, a);
            ptr_m = addr;
        end
        start_c();
        send_byte(DR, 1'b1, 1, a);
        for (int i = 0; i < n; i++) begin
            recv_byte(mem_m[ptr_m], i < n - 1, g);
            check(req, int'(g), int'(mem_m[ptr_m]));
            ptr_m = (ptr_m + 1) % 256;
        end
        stop_c();
    endtask

    initial begin
        logic       a;
        logic [7:0] g;
        int         t;
        logic       s;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        clk_n(5);
        rst_n = 1'b1;
        clk_n(3);
        check("R4 reset pull", int'(pull), 0);

        // R5: single byte write then read-back through an address phase
        req = "R5";
        write_seq(8'h10, '{8'h5C});
        read_seq(8'h10, 1);

        // R6: page write wrapping inside an 8-byte page
        req = "R6";
        write_seq(8'h1D, '{8'h11, 8'h12, 8'h13, 8'h14, 8'h15});
        write_seq(8'h20, '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4,
                           8'hA5, 8'hA6, 8'hA7, 8'hA8, 8'hA9});
        read_seq(8'h18, 8);
        read_seq(8'h20, 8);

        // R8 and R9: chosen-address read crossing a page boundary
        req = "R8";
        read_seq(8'h1D, 5);

        // R7: read from the current pointer
        req = "R7";
        read_seq(-1, 2);

        // R9: wrap from the last byte to address 0
        req = "R9";
        write_seq(8'hFF, '{8'h77});
        write_seq(8'h00, '{8'h88});
        read_seq(8'hFE, 4);

        // R10: host refuses a byte; further clocks draw nothing
        req = "R10";
        start_c();
        send_byte(DR, 1'b1, 1, a);
        recv_byte(mem_m[ptr_m], 0, g);
        check("R10 byte", int'(g), int'(mem_m[ptr_m]));
        ptr_m = (ptr_m + 1) % 256;
        for (int i = 0; i < 9; i++) bit_cycle(1'b1, 1'b0, 1, s);
        stop_c();
        read_seq(-1, 1);

        // R2: wrong fixed nibble, then a trailing byte; nothing written
        req = "R2";
        start_c();
        send_byte(8'hBA, 1'b0, 1, a);
        send_byte(8'h33, 1'b0, 1, a);
        send_byte(8'h99, 1'b0, 1, a);
        stop_c();
        poll(t);
        check("R2 no commit", t, 1);
        read_seq(8'h33, 1);

        // R3: strap mismatch in either direction
        req = "R3";
        start_c();
        send_byte(8'hA8, 1'b0, 1, a);
        stop_c();
        start_c();
        send_byte(8'hAF, 1'b0, 1, a);
        stop_c();

        // R13: address-only write leaves pointer at that address
        req = "R13";
        write_seq(8'h1E, '{});
        read_seq(-1, 1);

        // R1: START in the middle of a data byte
        req = "R1";
        start_c();
        send_byte(DW, 1'b1, 1, a);
        send_byte(8'h1F, 1'b1, 1, a);
        ptr_m = 8'h1F;
        bit_cycle(1'b1, 1'b0, 1, s);
        bit_cycle(1'b0, 1'b0, 1, s);
        bit_cycle(1'b1, 1'b0, 1, s);
        bit_cycle(1'b0, 1'b0, 1, s);
        read_seq(-1, 1);
        poll(t);
        check("R1 aborted byte not committed", t, 1);

        // R12: MSB-first data with mixed bit patterns
        req = "R12";
        write_seq(8'h40, '{8'h80, 8'h01, 8'h5A, 8'hC3});
        read_seq(8'h40, 4);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule